// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a small multicycle processor whose datapath is one byte wide. Each 32-bit instruction is fetched one byte per cycle, so a fetch takes four cycles. Decode follows, and then a short tail of steps that depends on the instruction class. The block takes the opcode and function fields that the datapath's instruction register presents. It produces every strobe and select line the datapath needs, plus the 3-bit operation code for the ALU.

All strobes are decoded from the current state alone, so they are glitch-free registered-state functions. Any strobe that a state does not name is driven low. The supported classes are register-register arithmetic, byte load, byte store, branch-if-equal and unconditional jump. An instruction therefore spends between six and eight cycles in the sequencer. An unknown opcode costs five cycles and writes nothing.

Opcode encodings are as follows:

| Instruction class | Opcode |
|---|---|
| Register-register | `000000` |
| Byte load | `100000` |
| Byte store | `101000` |
| Branch-if-equal | `000100` |
| Jump | `000010` |

The ALU code values are add `010`, subtract `110`, AND `000`, OR `001` and set-less-than `111`.

Top module: `cpu_ctl_top`

## Requirements
- R1: With `rst` high, the next clock puts the sequencer in the first fetch step, and it stays there while `rst` is high. That step drives `memRd`=1, `addrSel`=0, `srcASel`=0, `srcBSel`=01, `aluMode`=00, `pcWe`=1, `pcSel`=00 and `irLoad`=0001, with every other strobe at 0.
- R2: The fetch steps raise `irLoad[0]`, `irLoad[1]`, `irLoad[2]` and `irLoad[3]` on four consecutive cycles, in that order. Each fetch cycle carries the same memory-read and PC-increment strobes as in R1.
- R3: The cycle after the last fetch byte is decode. It drives `srcASel`=0, `srcBSel`=11 and `aluMode`=00, with every other strobe at 0.
- R4: After decode, a byte load runs three steps and then returns to fetch, for 8 cycles in total.
  - Address step: `srcASel`=1, `srcBSel`=10, `aluMode`=00.
  - Read step: `memRd`=1, `addrSel`=1.
  - Write-back step: `regWe`=1, `wbFromMem`=1, `dstFromRd`=0.
- R5: After decode, a byte store runs the same address step and then one write step (`memWr`=1, `addrSel`=1). It then returns to fetch, for 7 cycles in total.
- R6: After decode, a register-register instruction runs an execute step (`srcASel`=1, `srcBSel`=00, `aluMode`=10). It follows with a completion step (`regWe`=1, `dstFromRd`=1, `wbFromMem`=0), for 7 cycles in total.
- R7: After decode, a branch runs one step and then returns to fetch, for 6 cycles in total. That step drives `srcASel`=1, `srcBSel`=00, `aluMode`=01, `pcWeIfEq`=1 and `pcSel`=01.
- R8: After decode, a jump runs one step (`pcWe`=1, `pcSel`=10) and then returns to fetch, for 6 cycles in total.
- R9: Any other opcode goes straight from decode back to the first fetch step, with no memory write, register write or PC write.
- R10: `aluCtl` is 010 when `aluMode`=00 and 110 when `aluMode`=01, whatever the value of `funct`.
- R11: When `aluMode`=10, `aluCtl` follows `funct`:
  - 100000 gives 010.
  - 100010 gives 110.
  - 100100 gives 000.
  - 100101 gives 001.
  - 101010 gives 111.
  - Any other value gives 010.
- R12: `memRd` and `memWr` are never high together. At most one `irLoad` bit is high. `pcWe` and `pcWeIfEq` are never high together.
- R13: The value of `opcode` during fetch cycles has no effect on the fetch sequence or its strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field from the instruction register |
| funct | input | 6 | Function field from the instruction register |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| addrSel | output | 1 | Memory address source: 0 = PC, 1 = ALU result register |
| irLoad | output | 4 | One load enable per instruction byte |
| wbFromMem | output | 1 | Register write data source: 1 = memory data register, 0 = ALU result |
| dstFromRd | output | 1 | Destination register field: 1 = rd field, 0 = rt field |
| regWe | output | 1 | Register file write enable |
| srcASel | output | 1 | ALU input A: 0 = PC, 1 = register A |
| srcBSel | output | 2 | ALU input B: 00 = register B, 01 = constant one, 10 = immediate, 11 = branch offset |
| aluMode | output | 2 | ALU operation class: 00 = add, 01 = subtract, 10 = function field |
| pcSel | output | 2 | PC source: 00 = ALU output, 01 = ALU result register, 10 = jump target |
| pcWe | output | 1 | Unconditional PC write |
| pcWeIfEq | output | 1 | PC write qualified by the datapath's zero flag |
| aluCtl | output | 3 | Operation code for the ALU |

## Verification
The assertions rely on the datapath holding `opcode` and `funct` steady from decode until the instruction returns to fetch. The instruction register cannot change then, because no `irLoad` bit is active. The bench respects this by driving the real opcode and function fields only in post-fetch cycles. During fetch cycles it drives pseudo-random values on both fields, which also exercises R13. Reset is applied both from power-up and in the middle of a byte load, so the return to the first fetch step is seen from a non-fetch state.

// File: rtl/cpu_ctl_pkg.sv
package cpu_ctl_pkg;

  parameter int OP_W = 6;
  parameter int FN_W = 6;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OP_W-1:0] OPC_LB    = 6'b100000;
  localparam logic [OP_W-1:0] OPC_SB    = 6'b101000;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_J     = 6'b000010;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_AND = 6'b100100;
  localparam logic [FN_W-1:0] FN_OR  = 6'b100101;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;

  localparam logic [1:0] MODE_ADD  = 2'b00;
  localparam logic [1:0] MODE_SUB  = 2'b01;
  localparam logic [1:0] MODE_FUNC = 2'b10;

  localparam logic [1:0] SRCB_REG = 2'b00;
  localparam logic [1:0] SRCB_ONE = 2'b01;
  localparam logic [1:0] SRCB_IMM = 2'b10;
  localparam logic [1:0] SRCB_OFS = 2'b11;

  localparam logic [1:0] PCS_ALU  = 2'b00;
  localparam logic [1:0] PCS_OUT  = 2'b01;
  localparam logic [1:0] PCS_JMP  = 2'b10;

  localparam logic [2:0] AC_AND = 3'b000;
  localparam logic [2:0] AC_OR  = 3'b001;
  localparam logic [2:0] AC_ADD = 3'b010;
  localparam logic [2:0] AC_SUB = 3'b110;
  localparam logic [2:0] AC_SLT = 3'b111;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MEMADR, ST_LDRD, ST_LDWB,
    ST_STWR, ST_REXEC, ST_RWB, ST_BRANCH, ST_JUMP
  } phase_e;

  typedef struct packed {
    logic       memRd;
    logic       memWr;
    logic       addrSel;
    logic       wbFromMem;
    logic       dstFromRd;
    logic       regWe;
    logic       srcASel;
    logic [1:0] srcBSel;
    logic [1:0] aluMode;
    logic [1:0] pcSel;
    logic       pcWe;
    logic       pcWeIfEq;
  } strobe_t;

endpackage

// File: rtl/cpu_ctl_seq.sv
module cpu_ctl_seq
  import cpu_ctl_pkg::*;
#(
  parameter int IR_BYTES = 4,
  localparam int IDX_W = (IR_BYTES > 1) ? $clog2(IR_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output phase_e          phase,
  output logic [IDX_W-1:0] byteIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(IR_BYTES - 1);

  phase_e           phaseNext;
  logic [IDX_W-1:0] idxNext;

  always_comb begin
    phaseNext = ST_FETCH;
    idxNext   = '0;
    unique case (phase)
      ST_FETCH: begin
        if (byteIdx == LAST_IDX) begin
          phaseNext = ST_DECODE;
        end else begin
          phaseNext = ST_FETCH;
          idxNext   = byteIdx + 1'b1;
        end
      end
      ST_DECODE: begin
        case (opcode)
          OPC_LB, OPC_SB: phaseNext = ST_MEMADR;
          OPC_RTYPE:      phaseNext = ST_REXEC;
          OPC_BEQ:        phaseNext = ST_BRANCH;
          OPC_J:          phaseNext = ST_JUMP;
          default:        phaseNext = ST_FETCH;
        endcase
      end
      ST_MEMADR: begin
        if (opcode == OPC_LB)      phaseNext = ST_LDRD;
        else if (opcode == OPC_SB) phaseNext = ST_STWR;
        else                       phaseNext = ST_FETCH;
      end
      ST_LDRD:  phaseNext = ST_LDWB;
      ST_REXEC: phaseNext = ST_RWB;
      default:  phaseNext = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= ST_FETCH;
      byteIdx <= '0;
    end else begin
      phase   <= phaseNext;
      byteIdx <= idxNext;
    end
  end

endmodule

// File: rtl/cpu_ctl_decode.sv
module cpu_ctl_decode
  import cpu_ctl_pkg::*;
#(
  parameter int IR_BYTES = 4,
  localparam int IDX_W = (IR_BYTES > 1) ? $clog2(IR_BYTES) : 1
) (
  input  phase_e              phase,
  input  logic [IDX_W-1:0]    byteIdx,
  output strobe_t             strobe,
  output logic [IR_BYTES-1:0] irLoad
);

  for (genvar g = 0; g < IR_BYTES; g++) begin : g_irbyte
    assign irLoad[g] = (phase == ST_FETCH) && (byteIdx == IDX_W'(g));
  end

  always_comb begin
    strobe = '0;
    unique case (phase)
      ST_FETCH: begin
        strobe.memRd   = 1'b1;
        strobe.srcBSel = SRCB_ONE;
        strobe.aluMode = MODE_ADD;
        strobe.pcSel   = PCS_ALU;
        strobe.pcWe    = 1'b1;
      end
      ST_DECODE: begin
        strobe.srcBSel = SRCB_OFS;
        strobe.aluMode = MODE_ADD;
      end
      ST_MEMADR: begin
        strobe.srcASel = 1'b1;
        strobe.srcBSel = SRCB_IMM;
        strobe.aluMode = MODE_ADD;
      end
      ST_LDRD: begin
        strobe.memRd   = 1'b1;
        strobe.addrSel = 1'b1;
      end
      ST_LDWB: begin
        strobe.regWe     = 1'b1;
        strobe.wbFromMem = 1'b1;
      end
      ST_STWR: begin
        strobe.memWr   = 1'b1;
        strobe.addrSel = 1'b1;
      end
      ST_REXEC: begin
        strobe.srcASel = 1'b1;
        strobe.srcBSel = SRCB_REG;
        strobe.aluMode = MODE_FUNC;
      end
      ST_RWB: begin
        strobe.regWe     = 1'b1;
        strobe.dstFromRd = 1'b1;
      end
      ST_BRANCH: begin
        strobe.srcASel  = 1'b1;
        strobe.srcBSel  = SRCB_REG;
        strobe.aluMode  = MODE_SUB;
        strobe.pcWeIfEq = 1'b1;
        strobe.pcSel    = PCS_OUT;
      end
      ST_JUMP: begin
        strobe.pcWe  = 1'b1;
        strobe.pcSel = PCS_JMP;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/cpu_alu_ctl.sv
module cpu_alu_ctl
  import cpu_ctl_pkg::*;
(
  input  logic [1:0]      aluMode,
  input  logic [FN_W-1:0] funct,
  output logic [2:0]      aluCtl
);

  logic [2:0] fnCode;

  always_comb begin
    case (funct)
      FN_SUB:  fnCode = AC_SUB;
      FN_AND:  fnCode = AC_AND;
      FN_OR:   fnCode = AC_OR;
      FN_SLT:  fnCode = AC_SLT;
      default: fnCode = AC_ADD;
    endcase
  end

  always_comb begin
    case (aluMode)
      MODE_SUB:  aluCtl = AC_SUB;
      MODE_FUNC: aluCtl = fnCode;
      default:   aluCtl = AC_ADD;
    endcase
  end

endmodule

// File: rtl/cpu_ctl_top.sv
module cpu_ctl_top
  import cpu_ctl_pkg::*;
#(
  parameter int IR_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [5:0]          opcode,
  input  logic [5:0]          funct,
  output logic                memRd,
  output logic                memWr,
  output logic                addrSel,
  output logic [IR_BYTES-1:0] irLoad,
  output logic                wbFromMem,
  output logic                dstFromRd,
  output logic                regWe,
  output logic                srcASel,
  output logic [1:0]          srcBSel,
  output logic [1:0]          aluMode,
  output logic [1:0]          pcSel,
  output logic                pcWe,
  output logic                pcWeIfEq,
  output logic [2:0]          aluCtl
);

  localparam int IDX_W = (IR_BYTES > 1) ? $clog2(IR_BYTES) : 1;

  phase_e           phase;
  logic [IDX_W-1:0] byteIdx;
  strobe_t          strobe;

  cpu_ctl_seq #(.IR_BYTES(IR_BYTES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .phase   (phase),
    .byteIdx (byteIdx)
  );

  cpu_ctl_decode #(.IR_BYTES(IR_BYTES)) u_dec (
    .phase   (phase),
    .byteIdx (byteIdx),
    .strobe  (strobe),
    .irLoad  (irLoad)
  );

  cpu_alu_ctl u_alu (
    .aluMode (strobe.aluMode),
    .funct   (funct),
    .aluCtl  (aluCtl)
  );

  assign memRd     = strobe.memRd;
  assign memWr     = strobe.memWr;
  assign addrSel   = strobe.addrSel;
  assign wbFromMem = strobe.wbFromMem;
  assign dstFromRd = strobe.dstFromRd;
  assign regWe     = strobe.regWe;
  assign srcASel   = strobe.srcASel;
  assign srcBSel   = strobe.srcBSel;
  assign aluMode   = strobe.aluMode;
  assign pcSel     = strobe.pcSel;
  assign pcWe      = strobe.pcWe;
  assign pcWeIfEq  = strobe.pcWeIfEq;

endmodule

// File: rtl/cpu_ctl_chk.sv
module cpu_ctl_chk #(
  parameter int IR_BYTES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                memRd,
  input logic                memWr,
  input logic                addrSel,
  input logic [IR_BYTES-1:0] irLoad,
  input logic                wbFromMem,
  input logic                dstFromRd,
  input logic                regWe,
  input logic                srcASel,
  input logic [1:0]          srcBSel,
  input logic [1:0]          aluMode,
  input logic [1:0]          pcSel,
  input logic                pcWe,
  input logic                pcWeIfEq,
  input logic [2:0]          aluCtl
);

  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (irLoad[0] && memRd && pcWe && !memWr && !regWe));

  p_fetch_strobes_r2: assert property (@(posedge clk) disable iff (rst)
    (irLoad != '0) |-> (memRd && !addrSel && pcWe && pcSel == 2'b00 &&
                        srcBSel == 2'b01 && !srcASel && aluMode == 2'b00));

  p_byte_order_r2: assert property (@(posedge clk) disable iff (rst)
    (irLoad != '0 && !irLoad[IR_BYTES-1]) |=> (irLoad == ($past(irLoad) << 1)));

  p_decode_r3: assert property (@(posedge clk) disable iff (rst)
    irLoad[IR_BYTES-1] |=> (srcBSel == 2'b11 && !srcASel && aluMode == 2'b00 &&
                            !memRd && !memWr && !regWe && !pcWe && !pcWeIfEq));

  p_load_wb_r4: assert property (@(posedge clk) disable iff (rst)
    (memRd && addrSel) |=> (regWe && wbFromMem && !dstFromRd));

  p_store_ret_r5: assert property (@(posedge clk) disable iff (rst)
    memWr |=> (irLoad[0] && !memWr));

  p_rtype_wb_r6: assert property (@(posedge clk) disable iff (rst)
    (srcASel && srcBSel == 2'b00 && aluMode == 2'b10) |=> (regWe && dstFromRd && !wbFromMem));

  p_branch_ret_r7: assert property (@(posedge clk) disable iff (rst)
    pcWeIfEq |=> irLoad[0]);

  p_jump_ret_r8: assert property (@(posedge clk) disable iff (rst)
    (pcWe && pcSel == 2'b10) |=> irLoad[0]);

  p_sub_code_r10: assert property (@(posedge clk) disable iff (rst)
    (aluMode == 2'b01) |-> (aluCtl == 3'b110));

  p_rw_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(memRd && memWr));

  p_ir_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irLoad));

  p_pc_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(pcWe && pcWeIfEq));

endmodule

bind cpu_ctl_top cpu_ctl_chk #(.IR_BYTES(IR_BYTES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .memRd     (memRd),
  .memWr     (memWr),
  .addrSel   (addrSel),
  .irLoad    (irLoad),
  .wbFromMem (wbFromMem),
  .dstFromRd (dstFromRd),
  .regWe     (regWe),
  .srcASel   (srcASel),
  .srcBSel   (srcBSel),
  .aluMode   (aluMode),
  .pcSel     (pcSel),
  .pcWe      (pcWe),
  .pcWeIfEq  (pcWeIfEq),
  .aluCtl    (aluCtl)
);

// File: tb/sim_cpu_ctl_top.sv
`timescale 1ns/1ps
module sim_cpu_ctl_top;

  localparam int NB = 4;
  localparam int K_FETCH = 0, K_DEC = 1, K_ADR = 2, K_LDRD = 3, K_LDWB = 4,
                 K_STWR = 5, K_REX = 6, K_RWB = 7, K_BR = 8, K_JMP = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic memRd, memWr, addrSel, wbFromMem, dstFromRd, regWe, srcASel, pcWe, pcWeIfEq;
  logic [NB-1:0] irLoad;
  logic [1:0] srcBSel, aluMode, pcSel;
  logic [2:0] aluCtl;

  int checks = 0;
  int fails = 0;
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  always #2.5 clk = ~clk;

  cpu_ctl_top #(.IR_BYTES(NB)) u0 (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .memRd(memRd), .memWr(memWr), .addrSel(addrSel), .irLoad(irLoad),
    .wbFromMem(wbFromMem), .dstFromRd(dstFromRd), .regWe(regWe),
    .srcASel(srcASel), .srcBSel(srcBSel), .aluMode(aluMode), .pcSel(pcSel),
    .pcWe(pcWe), .pcWeIfEq(pcWeIfEq), .aluCtl(aluCtl)
  );

  function automatic logic [2:0] refAlu(input logic [1:0] mode, input logic [5:0] fn);
    if (mode == 2'b01) return 3'b110;
    if (mode != 2'b10) return 3'b010;
    if (fn == 6'b100010) return 3'b110;
    if (fn == 6'b100100) return 3'b000;
    if (fn == 6'b100101) return 3'b001;
    if (fn == 6'b101010) return 3'b111;
    return 3'b010;
  endfunction

  function automatic logic [21:0] expVec(input int kind, input int idx, input logic [5:0] fn);
    logic rd = 0, wr = 0, asel = 0, wbm = 0, drd = 0, rwe = 0, sa = 0, pw = 0, pwc = 0;
    logic [NB-1:0] ir = '0;
    logic [1:0] sb = 0, md = 0, ps = 0;
    case (kind)
      K_FETCH: begin rd = 1; sb = 2'b01; pw = 1; ir[idx] = 1'b1; end
      K_DEC:   sb = 2'b11;
      K_ADR:   begin sa = 1; sb = 2'b10; end
      K_LDRD:  begin rd = 1; asel = 1; end
      K_LDWB:  begin rwe = 1; wbm = 1; end
      K_STWR:  begin wr = 1; asel = 1; end
      K_REX:   begin sa = 1; md = 2'b10; end
      K_RWB:   begin rwe = 1; drd = 1; end
      K_BR:    begin sa = 1; md = 2'b01; pwc = 1; ps = 2'b01; end
      K_JMP:   begin pw = 1; ps = 2'b10; end
      default: ;
    endcase
    return {rd, wr, asel, ir, wbm, drd, rwe, sa, sb, md, ps, pw, pwc, refAlu(md, fn)};
  endfunction

  function automatic logic [21:0] actVec();
    return {memRd, memWr, addrSel, irLoad, wbFromMem, dstFromRd, regWe, srcASel,
            srcBSel, aluMode, pcSel, pcWe, pcWeIfEq, aluCtl};
  endfunction

  function automatic string tagOf(input int kind, input logic [5:0] op);
    case (kind)
      K_FETCH:       return "R2 R13";
      K_DEC:         return (op == 6'b000100) ? "R3 R10" : "R3 R9";
      K_ADR:         return (op == 6'b100000) ? "R4" : "R5";
      K_LDRD, K_LDWB: return "R4";
      K_STWR:        return "R5";
      K_REX, K_RWB:  return "R6 R11";
      K_BR:          return "R7 R10";
      default:       return "R8";
    endcase
  endfunction

  task automatic compare(input logic [21:0] expv, input string tag);
    logic [21:0] got = actVec();
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: outputs %b expected %b at %0t", tag, got, expv, $time);
    end
    checks++;
    if ((memRd && memWr) || $countones(irLoad) > 1 || (pcWe && pcWeIfEq)) begin
      fails++;
      $display("FAIL R12: exclusive strobes clash, outputs %b expected none at %0t", got, $time);
    end
  endtask

  task automatic step(input int kind, input int idx, input logic [5:0] op,
                      input logic [5:0] fn);
    if (kind == K_FETCH) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      opcode = lfsr[5:0];
      funct  = lfsr[11:6];
    end else begin
      opcode = op;
      funct  = fn;
    end
    #1;
    compare(expVec(kind, idx, funct), tagOf(kind, op));
    @(negedge clk);
  endtask

  task automatic runInstr(input logic [5:0] op, input logic [5:0] fn, input int maxSteps);
    int kinds[$];
    for (int b = 0; b < NB; b++) kinds.push_back(K_FETCH);
    kinds.push_back(K_DEC);
    case (op)
      6'b100000: begin kinds.push_back(K_ADR); kinds.push_back(K_LDRD); kinds.push_back(K_LDWB); end
      6'b101000: begin kinds.push_back(K_ADR); kinds.push_back(K_STWR); end
      6'b000000: begin kinds.push_back(K_REX); kinds.push_back(K_RWB); end
      6'b000100: kinds.push_back(K_BR);
      6'b000010: kinds.push_back(K_JMP);
      default: ;
    endcase
    for (int i = 0; i < kinds.size() && i < maxSteps; i++)
      step(kinds[i], (i < NB) ? i : 0, op, fn);
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    compare(expVec(K_FETCH, 0, funct), "R1");
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: cycles %0d expected fewer", 100000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    doReset();
    runInstr(6'b100000, 6'b000000, 99);   // R4 load
    runInstr(6'b101000, 6'b000000, 99);   // R5 store
    runInstr(6'b000000, 6'b100000, 99);   // R6 R11 add
    runInstr(6'b000000, 6'b100010, 99);   // R11 subtract
    runInstr(6'b000000, 6'b100100, 99);   // R11 and
    runInstr(6'b000000, 6'b100101, 99);   // R11 or
    runInstr(6'b000000, 6'b101010, 99);   // R11 set-less-than
    runInstr(6'b000000, 6'b000111, 99);   // R11 unlisted funct
    runInstr(6'b000100, 6'b101010, 99);   // R7 R10 branch
    runInstr(6'b000010, 6'b100010, 99);   // R8 jump
    runInstr(6'b111111, 6'b000000, 99);   // R9 unknown opcode
    runInstr(6'b001000, 6'b000000, 99);   // R9 unknown opcode
    runInstr(6'b100000, 6'b000000, 6);    // load cut short by R1 reset
    doReset();
    runInstr(6'b101000, 6'b000000, 99);
    runInstr(6'b000010, 6'b000000, 99);
    runInstr(6'b000100, 6'b000000, NB);   // final return-to-fetch check
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule